// File: doc/BRIEF.md
# Auto-Ranging Frequency Measurement Sequencer

This block runs a gated frequency counter on behalf of a requester and returns the best-precision reading for one selected clock source. A request carries a 7-bit source number. The sequencer programs the counter with its longest gate window and polls the counter's busy flag. It then reads the count. If the count has saturated, it repeats the whole attempt with a gate that is 32 us shorter. Once a count fits, it converts the count to hertz with rounding, computes the precision of that window, and reports the result with a single-cycle done pulse.

The request side is a valid/ready handshake. `req_ready` is high only while the block is idle, so a requester that holds `req_valid` high simply waits; nothing is queued. The result side has no back-pressure. `res_valid` is a one-cycle strobe, and the result fields stay unchanged until the next strobe.

The counter is reached through a simple register port. A write completes in the cycle its strobe is high. Read data must be presented on `bus_rdata` in the cycle after the read strobe. Register word index 1 is the counter control word and word index 3 is the count result. The control word fields are as follows: duration (gate minus one) in bits 15:0, enable in bit 16, run in bit 19, source in bits 26:20, and busy (read only) in bit 31.

Top module: `msr_autorange`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request is taken when `req_valid` and `req_ready` are both high. While a sequence runs, `req_valid` and `req_src` have no effect: the source written to the counter stays the one accepted, and exactly one done pulse follows each accepted request.
- R2: Each attempt makes four writes to control word index 1, in this order: 0; then the duration field (bits 15:0) set to gate-1; then the same value with the source in bits 26:20; then the same value with enable (bit 16) and run (bit 19) set. No other bits are set in these writes.
- R3: The first attempt uses a 640 us gate. Each retry uses a gate 32 us shorter than the one before. No gate below 32 us is ever programmed.
- R4: A count read from result word index 3 counts as saturated when its full 32-bit value is 0xFFFF or greater. A saturated count leads to a retry or to an overflow error. A smaller count ends the search.
- R5: After the go write, control word index 1 is read every POLL_CYC cycles or more. When busy (bit 31) reads 0, control is written once with enable (bit 16) cleared and the duration and source unchanged. Only after that write is result word index 3 read.
- R6: If MAX_POLLS reads in a row all return busy set, the sequence ends with `res_tmo`=1, frequency 0 and precision 0, and the result word is never read. If busy clears on read number MAX_POLLS, the measurement completes normally.
- R7: A good reading reports `res_freq` = (count*1,000,000 + gate/2) / gate, using integer division. This is the count scaled to hertz and rounded to nearest.
- R8: A good reading reports `res_prec` = floor(2,000,000 / gate), for example 3125 at 640 and 62500 at 32.
- R9: If the count is still saturated at the 32 us gate, the result carries `res_ovf`=1, frequency 0 and precision 0. `res_ovf` and `res_tmo` are never both set.
- R10: `res_valid` is high for exactly one cycle per sequence. `res_freq`, `res_prec`, `res_ovf` and `res_tmo` change only in a cycle where `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Measurement request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_src | input | 7 | Clock source number to measure |
| bus_en | output | 1 | Register access strobe |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 2 | Register word index (1 control, 3 result) |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid the cycle after a read strobe |
| res_valid | output | 1 | One-cycle done strobe |
| res_freq | output | 32 | Measured frequency in Hz |
| res_prec | output | 32 | Precision of the reading in Hz |
| res_ovf | output | 1 | Count saturated at the shortest gate |
| res_tmo | output | 1 | Busy never cleared within the poll limit |

## Verification
The bench sweeps source frequencies that sit on each side of the saturation point. One is just below 0xFFFF at the longest gate and one lands on 0xFFFF exactly. Others return counts far above 0xFFFF, and one fits only at the 32 us gate. A compare on equality instead of on "0xFFFF or more", or a search that skips a step, would report the wrong gate or a wrong rounded frequency. The busy model holds busy for exactly MAX_POLLS-1 reads and for MAX_POLLS reads. An off-by-one in the poll limit shows up as a false timeout or a missed one. The counter model checks the order of the control writes and flags any result read made while enable is still set. Requests are injected mid-sequence; a design that latched them would write the wrong source or raise a second done.

// File: rtl/msr_pkg.sv
package msr_pkg;
  // Counter register word indices
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_RES  = 2'd3;

  // Control word layout, fixed by the counter that decodes it
  localparam int DUR_W    = 16;
  localparam int EN_BIT   = 16;
  localparam int RUN_BIT  = 19;
  localparam int SRC_LSB  = 20;
  localparam int SRC_W    = 7;
  localparam int BUSY_BIT = 31;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_DUR, ST_SRC, ST_GO, ST_WAIT, ST_PRD, ST_PCHK,
    ST_STOP, ST_RRD, ST_RCHK, ST_DGO, ST_DWAIT, ST_DONE
  } seq_state_t;

  function automatic logic [31:0] mk_ctrl(input logic [DUR_W-1:0] dur,
                                          input logic [SRC_W-1:0] src,
                                          input logic en, input logic run);
    logic [31:0] w;
    w = '0;
    w[DUR_W-1:0] = dur;
    w[SRC_LSB +: SRC_W] = src;
    w[EN_BIT] = en;
    w[RUN_BIT] = run;
    return w;
  endfunction
endpackage

// File: rtl/msr_divider.sv
module msr_divider #(
  parameter int NUM_W = 37,
  parameter int DEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [CW-1:0]    cnt;
  logic             run;
  logic [DEN_W:0]   shifted;
  logic             ge;

  assign shifted = {rem, quot[NUM_W-1]};
  assign ge      = shifted >= {1'b0, den};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
      quot <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        quot <= num;
        cnt  <= CW'(NUM_W);
        run  <= 1'b1;
      end else if (run) begin
        rem  <= ge ? DEN_W'(shifted - {1'b0, den}) : shifted[DEN_W-1:0];
        quot <= {quot[NUM_W-2:0], ge};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/msr_poll_timer.sv
module msr_poll_timer #(
  parameter int POLL_CYC  = 1000,
  parameter int MAX_POLLS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clr_polls,
  input  logic inc_polls,
  output logic expired,
  output logic last_poll
);
  localparam int WW = $clog2(POLL_CYC + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [WW-1:0] wait_cnt;
  logic [PW-1:0] poll_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      poll_cnt <= '0;
    end else begin
      if (arm) wait_cnt <= WW'(POLL_CYC - 1);
      else if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
      if (clr_polls) poll_cnt <= '0;
      else if (inc_polls) poll_cnt <= poll_cnt + 1'b1;
    end
  end

  assign expired   = (wait_cnt == '0);
  assign last_poll = (poll_cnt == PW'(MAX_POLLS - 1));
endmodule

// File: rtl/msr_autorange.sv
module msr_autorange
  import msr_pkg::*;
#(
  parameter int GATE_MAX  = 640,
  parameter int GATE_STEP = 32,
  parameter int GATE_MIN  = 32,
  parameter int CNT_W     = 16,
  parameter int SCALE     = 1000000,
  parameter int POLL_CYC  = 1000,
  parameter int MAX_POLLS = 1000,
  parameter int FREQ_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [6:0]        req_src,
  output logic              bus_en,
  output logic              bus_we,
  output logic [1:0]        bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  output logic              res_valid,
  output logic [FREQ_W-1:0] res_freq,
  output logic [FREQ_W-1:0] res_prec,
  output logic              res_ovf,
  output logic              res_tmo
);
  localparam int DEN_W = $clog2(GATE_MAX + 1);
  localparam int NUM_W = CNT_W + $clog2(2 * SCALE) + 1;
  localparam logic [31:0] SAT = 32'((1 << CNT_W) - 1);

  seq_state_t       state;
  logic [DEN_W-1:0] gate;
  logic [SRC_W-1:0] src_q;
  logic [CNT_W-1:0] count_q;
  logic [DUR_W-1:0] dur;
  logic             busy_rd, saturated, can_retry;
  logic             t_arm, t_clr, t_inc, t_exp, t_last;
  logic             div_go, f_done, p_done;
  logic [NUM_W-1:0] f_num, f_quot, p_quot;

  assign dur       = DUR_W'(gate) - DUR_W'(1);
  assign busy_rd   = bus_rdata[BUSY_BIT];
  assign saturated = bus_rdata >= SAT;
  assign can_retry = gate >= DEN_W'(GATE_MIN + GATE_STEP);
  assign req_ready = (state == ST_IDLE);
  assign res_valid = (state == ST_DONE);

  assign t_clr  = (state == ST_GO);
  assign t_inc  = (state == ST_PCHK) && busy_rd;
  assign t_arm  = t_clr || (t_inc && !t_last);
  assign div_go = (state == ST_DGO);
  assign f_num  = NUM_W'(count_q) * NUM_W'(SCALE) + NUM_W'(gate >> 1);

  msr_poll_timer #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(t_arm), .clr_polls(t_clr),
    .inc_polls(t_inc), .expired(t_exp), .last_poll(t_last));

  msr_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div_freq (
    .clk(clk), .rst_n(rst_n), .start(div_go), .num(f_num), .den(gate),
    .done(f_done), .quot(f_quot));

  msr_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div_prec (
    .clk(clk), .rst_n(rst_n), .start(div_go), .num(NUM_W'(2 * SCALE)), .den(gate),
    .done(p_done), .quot(p_quot));

  // Register port, decoded from the state
  always_comb begin
    bus_en    = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = ADDR_CTRL;
    bus_wdata = '0;
    unique case (state)
      ST_CLR:  begin bus_en = 1'b1; bus_we = 1'b1; end
      ST_DUR:  begin bus_en = 1'b1; bus_we = 1'b1; bus_wdata = mk_ctrl(dur, '0, 1'b0, 1'b0); end
      ST_SRC:  begin bus_en = 1'b1; bus_we = 1'b1; bus_wdata = mk_ctrl(dur, src_q, 1'b0, 1'b0); end
      ST_GO:   begin bus_en = 1'b1; bus_we = 1'b1; bus_wdata = mk_ctrl(dur, src_q, 1'b1, 1'b1); end
      ST_PRD:  begin bus_en = 1'b1; end
      ST_STOP: begin bus_en = 1'b1; bus_we = 1'b1; bus_wdata = mk_ctrl(dur, src_q, 1'b0, 1'b1); end
      ST_RRD:  begin bus_en = 1'b1; bus_addr = ADDR_RES; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      gate     <= DEN_W'(GATE_MAX);
      src_q    <= '0;
      count_q  <= '0;
      res_freq <= '0;
      res_prec <= '0;
      res_ovf  <= 1'b0;
      res_tmo  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          src_q <= req_src;
          gate  <= DEN_W'(GATE_MAX);
          state <= ST_CLR;
        end
        ST_CLR:  state <= ST_DUR;
        ST_DUR:  state <= ST_SRC;
        ST_SRC:  state <= ST_GO;
        ST_GO:   state <= ST_WAIT;
        ST_WAIT: if (t_exp) state <= ST_PRD;
        ST_PRD:  state <= ST_PCHK;
        ST_PCHK: begin
          if (!busy_rd) state <= ST_STOP;
          else if (t_last) begin
            res_freq <= '0;
            res_prec <= '0;
            res_ovf  <= 1'b0;
            res_tmo  <= 1'b1;
            state    <= ST_DONE;
          end else state <= ST_WAIT;
        end
        ST_STOP: state <= ST_RRD;
        ST_RRD:  state <= ST_RCHK;
        ST_RCHK: begin
          if (!saturated) begin
            count_q <= bus_rdata[CNT_W-1:0];
            state   <= ST_DGO;
          end else if (can_retry) begin
            gate  <= gate - DEN_W'(GATE_STEP);
            state <= ST_CLR;
          end else begin
            res_freq <= '0;
            res_prec <= '0;
            res_ovf  <= 1'b1;
            res_tmo  <= 1'b0;
            state    <= ST_DONE;
          end
        end
        ST_DGO:  state <= ST_DWAIT;
        ST_DWAIT: if (f_done && p_done) begin
          res_freq <= FREQ_W'(f_quot);
          res_prec <= FREQ_W'(p_quot);
          res_ovf  <= 1'b0;
          res_tmo  <= 1'b0;
          state    <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msr_autorange_chk.sv
module msr_autorange_chk
  import msr_pkg::*;
#(
  parameter int GATE_MAX  = 640,
  parameter int GATE_STEP = 32,
  parameter int GATE_MIN  = 32,
  parameter int FREQ_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_en,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              res_valid,
  input logic [FREQ_W-1:0] res_freq,
  input logic [FREQ_W-1:0] res_prec,
  input logic              res_ovf,
  input logic              res_tmo
);
  logic        en_live;
  logic [16:0] gate_w;
  logic        ctrl_wr;

  assign ctrl_wr = bus_en && bus_we && (bus_addr == ADDR_CTRL);
  assign gate_w  = {1'b0, bus_wdata[15:0]} + 17'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_live <= 1'b0;
    else if (ctrl_wr) en_live <= bus_wdata[EN_BIT];
  end

  AST_BUS_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> !req_ready); // R1
  AST_GATE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[EN_BIT]) |->
      (gate_w >= 17'(GATE_MIN) && gate_w <= 17'(GATE_MAX) &&
       ((17'(GATE_MAX) - gate_w) % 17'(GATE_STEP)) == 17'd0)); // R3
  AST_RESULT_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_RES) |-> !en_live); // R5
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_ovf || res_tmo)) |-> (res_freq == '0 && res_prec == '0)); // R9
  AST_ONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_ovf && res_tmo)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({res_freq, res_prec, res_ovf, res_tmo}) |-> res_valid); // R10
endmodule

bind msr_autorange msr_autorange_chk #(
  .GATE_MAX(GATE_MAX), .GATE_STEP(GATE_STEP), .GATE_MIN(GATE_MIN), .FREQ_W(FREQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .res_valid(res_valid),
  .res_freq(res_freq), .res_prec(res_prec), .res_ovf(res_ovf), .res_tmo(res_tmo)
);

// File: tb/tb_msr_autorange.sv
module tb_msr_autorange;
  localparam int POLLC = 4;
  localparam int MAXP  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  req_src = '0;
  logic        bus_en, bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        res_valid;
  logic [31:0] res_freq, res_prec;
  logic        res_ovf, res_tmo;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  msr_autorange #(.POLL_CYC(POLLC), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .res_valid(res_valid),
    .res_freq(res_freq), .res_prec(res_prec), .res_ovf(res_ovf), .res_tmo(res_tmo));

  // ---------------- counter model ----------------
  longint m_freq = 0;     // driven by bench only
  int     m_busy = 0;     // driven by bench only
  int     m_err = 0;
  int     m_res_reads = 0;
  int     m_step = 0;
  int     m_gate = 0;
  int     m_prev_gate = 0;
  int     m_busy_left = 0;
  logic [6:0]  m_src = '0;
  logic [31:0] m_ctrl = '0;
  int     done_cnt = 0;
  int     cycles = 0;

  function automatic longint cnt_of(longint f, int g);
    longint c;
    c = (f * g) / 1000000;
    if (c >= (1 << 20)) c = 65535;
    return c;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (res_valid) done_cnt++;
    if (req_valid && req_ready) begin
      m_step = 0; m_prev_gate = 0; m_res_reads = 0; m_src = req_src;
    end
    if (bus_en && bus_we) begin
      if (bus_addr != 2'd1) m_err++;
      else begin
        case (m_step)
          0, 5: begin
            if (m_step == 5) m_prev_gate = m_gate;
            if (bus_wdata != 0) m_err++;
            m_step = 1;
          end
          1: begin
            m_gate = int'(bus_wdata[15:0]) + 1;
            if (bus_wdata[31:16] != 0) m_err++;
            if (m_prev_gate == 0 && m_gate != 640) m_err++;            // R3
            if (m_prev_gate != 0 && m_gate != m_prev_gate - 32) m_err++; // R3
            if (m_gate < 32) m_err++;
            m_step = 2;
          end
          2: begin
            if (bus_wdata != (m_ctrl | {5'd0, m_src, 20'd0})) m_err++;  // R2, R1
            m_step = 3;
          end
          3: begin
            if (bus_wdata != (m_ctrl | 32'h0009_0000)) m_err++;          // R2
            m_busy_left = m_busy;
            m_step = 4;
          end
          4: begin
            if (m_busy_left != 0) m_err++;                              // R5
            if (bus_wdata != (m_ctrl & ~32'h0001_0000)) m_err++;         // R5
            m_step = 6;
          end
          default: m_err++;
        endcase
        m_ctrl = bus_wdata;
      end
    end else if (bus_en) begin
      if (bus_addr == 2'd1) begin
        if (m_step != 4) m_err++;
        bus_rdata <= (m_busy_left > 0) ? (m_ctrl | 32'h8000_0000) : m_ctrl;
        if (m_busy_left > 0) m_busy_left = m_busy_left - 1;
      end else if (bus_addr == 2'd3) begin
        if (m_step != 6) m_err++;                                       // R5
        m_step = 5;
        m_res_reads++;
        bus_rdata <= 32'(cnt_of(m_freq, m_gate));
      end else m_err++;
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input longint f, input int busy, input logic [6:0] src, input bit spur);
    longint c, e_f, e_p;
    int g;
    bit e_ovf, e_tmo;
    int err0, done0;
    logic [31:0] hf, hp;
    logic ho, ht;
    // expected values from the requirements
    e_f = 0; e_p = 0; e_ovf = 1'b0; e_tmo = 1'b0;
    if (busy >= MAXP) e_tmo = 1'b1;
    else begin
      e_ovf = 1'b1;
      for (int gg = 640; gg >= 32; gg -= 32) begin
        g = gg;
        c = cnt_of(f, g);
        if (c < 65535) begin
          e_f = (c * 1000000 + g / 2) / g;
          e_p = 2000000 / g;
          e_ovf = 1'b0;
          break;
        end
      end
    end
    m_freq = f; m_busy = busy;
    err0 = m_err; done0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_src = src;
    @(negedge clk);
    req_valid = 1'b0;
    if (spur) begin
      repeat (3) @(negedge clk);
      check(!req_ready, "R1 ready low while busy", req_ready, 0);
      req_valid = 1'b1; req_src = src ^ 7'h55;
      repeat (12) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!res_valid) @(negedge clk);
    check(res_tmo == e_tmo, "R6 timeout flag", res_tmo, e_tmo);
    check(res_ovf == e_ovf, "R9 overflow flag", res_ovf, e_ovf);
    check(res_freq == 32'(e_f), "R7 frequency", res_freq, e_f);
    check(res_prec == 32'(e_p), "R8 precision", res_prec, e_p);
    if (e_tmo) check(m_res_reads == 0, "R6 no result read", m_res_reads, 0);
    hf = res_freq; hp = res_prec; ho = res_ovf; ht = res_tmo;
    repeat (20) @(negedge clk);
    check(!res_valid, "R10 done one cycle", res_valid, 0);
    check(res_freq == hf && res_prec == hp && res_ovf == ho && res_tmo == ht,
          "R10 result held", res_freq, hf);
    check(done_cnt - done0 == 1, "R1 one done per request", done_cnt - done0, 1);
    check(m_err == err0, "R2 R3 R4 R5 bus sequence", m_err - err0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    check(res_valid == 1'b0 && bus_en == 1'b0, "R10 reset idle", res_valid, 0);
    check(res_freq == 0 && res_ovf == 0 && res_tmo == 0, "R10 reset outputs", res_freq, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    measure(0, 0, 7'd3, 1'b0);
    measure(32768, 1, 7'd20, 1'b0);
    measure(24000000, 2, 7'd44, 1'b1);              // R1 ignored start
    measure(102396875, 1, 7'd7, 1'b0);               // R4 count 65534 at 640
    measure(102398438, 1, 7'd8, 1'b0);               // R4 count 65535 at 640
    measure(166661458, 0, 7'd9, 1'b1);
    measure(1484656250, 3, 7'd55, 1'b0);
    measure(2047000000, 0, 7'd81, 1'b0);             // R3 fits only at 32
    measure(2100000000, 1, 7'd82, 1'b0);             // R9 saturated at every gate
    measure(30000000, MAXP - 1, 7'd11, 1'b0);        // R6 busy clears on last poll
    measure(30000000, MAXP, 7'd12, 1'b0);            // R6 timeout
    measure(30000000, 100, 7'd13, 1'b1);             // R6 timeout, stuck busy
    for (int k = 0; k < 12; k++)
      measure(longint'(k) * 187000000 + 7777, k % 5, 7'(k * 9), k[0]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule